// File: doc/BRIEF.md
# Watchdog with Keyed Refresh

This block is a down-counting watchdog. Software first programs a reload value and, if wanted, a seed byte. It then starts the timer with a control write. Once it runs, a timeout tick lowers the count. If a tick arrives while the count is already zero, the block pulses a reset request for one cycle. A write to the key register refreshes the watchdog by reloading the count.

In keyed mode a refresh is accepted only when the written byte equals the current state of a hidden 8-bit LFSR. The seed is that state when the timer starts. Each accepted refresh steps the LFSR once, so software must generate the same sequence itself, because the state cannot be read. Any other byte requests a reset at once, even if the count still has time left. A zero seed can never lead to a valid refresh, so starting keyed mode with a zero seed requests a reset on entry.

When a reset request fires, the block returns to its idle defaults in the same edge.

Top module: `wdt_keyed`

## Requirements
- R1: After `rst_n` is released, `rst_req` is 0 and the timer is idle: ticks cause no reset request.
- R2: A control write with `ctrl_run`=1 while idle starts the timer, with the count taken from the stored load value. A control write with `ctrl_run`=0 does not start it.
- R3: While running, each `tick` lowers the count by one. A `tick` that finds the count at zero raises `rst_req` in the next cycle, so a load value N expires on tick N+1.
- R4: With keyed mode off, a key write of any value while running reloads the count, and no comparison is made.
- R5: With keyed mode on, a key write equal to the expected byte reloads the count. The expected byte then steps once: it shifts left by one, and if the old bit 7 was 1 the result is XORed with 0x63 (polynomial x^8+x^6+x^5+x+1).
- R6: With keyed mode on, a key write that differs from the expected byte raises `rst_req` in the next cycle, whatever the count.
- R7: Starting in keyed mode with an expected byte of 0x00 raises `rst_req` in the next cycle.
- R8: While running, control writes are ignored, so the keyed setting cannot change. A key write that comes before the start sets the seed.
- R9: A valid refresh in the same cycle as an expiring tick wins: no reset request, and the count reloads.
- R10: `rst_req` is high for exactly one cycle, and the block is then idle. Later ticks cause no further request until it is started again.
- R11: A load write while running is stored and takes effect at the next reload.
- R12: With seed 0xAA the accepted keys are 0xAA, 0x37, 0x6E and then 0xDC. Writing 0x66 in place of 0xDC requests a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| tick | input | 1 | Timeout tick, one count step per high cycle |
| wr_load | input | 1 | Strobe that stores `load_val` |
| load_val | input | CNT_W | Reload value |
| wr_ctrl | input | 1 | Control write strobe |
| ctrl_run | input | 1 | Start bit of a control write |
| ctrl_secure | input | 1 | Keyed-mode bit of a control write |
| wr_key | input | 1 | Key write strobe (seed when idle, refresh when running) |
| key_val | input | 8 | Key byte |
| rst_req | output | 1 | One-cycle reset request |

## Verification
Refresh and expiry can fall in the same cycle. The bench lets the count reach zero and then drives a tick and a key write together. It does this once in plain mode and once in keyed mode, where the byte is the correct one. It expects no request and a fresh count, and a cycle-by-cycle reference model judges every cycle.

// File: rtl/wdt_keyed.sv
module wdt_keyed #(
  parameter int CNT_W = 16,
  parameter logic [7:0] TAPS = 8'h63
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             wr_ctrl,
  input  logic             ctrl_run,
  input  logic             ctrl_secure,
  input  logic             wr_key,
  input  logic [7:0]       key_val,
  output logic             rst_req
);

  logic             running, secure;
  logic [7:0]       lfsr_q;
  logic [CNT_W-1:0] cnt_q, load_q;

  wire [7:0] lfsr_nx  = {lfsr_q[6:0], 1'b0} ^ (lfsr_q[7] ? TAPS : 8'h00);
  wire       key_ok   = !secure || (key_val == lfsr_q && lfsr_q != 8'h00);
  wire       refresh  = running && wr_key && key_ok;
  wire       bad_key  = running && wr_key && !key_ok;
  wire       expire   = running && tick && cnt_q == '0 && !refresh;
  wire       start    = !running && wr_ctrl && ctrl_run;
  wire       zero_key = start && ctrl_secure && lfsr_q == 8'h00;
  wire       fire     = bad_key || expire || zero_key;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req <= 1'b0;
      running <= 1'b0;
      secure  <= 1'b0;
      lfsr_q  <= '0;
      cnt_q   <= '0;
      load_q  <= '0;
    end else begin
      rst_req <= fire;
      if (fire) begin
        running <= 1'b0;
        secure  <= 1'b0;
        lfsr_q  <= '0;
        cnt_q   <= '0;
        load_q  <= '0;
      end else begin
        if (wr_load) load_q <= load_val;
        if (start) begin
          running <= 1'b1;
          secure  <= ctrl_secure;
          cnt_q   <= load_q;
        end
        if (!running && wr_key) lfsr_q <= key_val;
        if (refresh) begin
          cnt_q <= load_q;
          if (secure) lfsr_q <= lfsr_nx;
        end else if (running && tick) begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

endmodule

module wdt_keyed_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             wr_ctrl,
  input logic             ctrl_run,
  input logic             ctrl_secure,
  input logic             wr_key,
  input logic [7:0]       key_val,
  input logic             rst_req,
  input logic             running,
  input logic             secure,
  input logic [7:0]       lfsr_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] load_q
);

  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R10
  idle_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> !running);

  // R6
  bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running && secure && wr_key && key_val != lfsr_q |=> rst_req);

  // R7
  zero_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running && wr_ctrl && ctrl_run && ctrl_secure && lfsr_q == 8'h00 |=> rst_req);

  // R3
  expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running && tick && !wr_key && cnt_q == '0 |=> rst_req);

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running && $past(running) |-> $stable(secure));

  // R5
  good_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running && secure && wr_key && key_val == lfsr_q && lfsr_q != 8'h00
    |=> !rst_req && cnt_q == $past(load_q));

endmodule

bind wdt_keyed wdt_keyed_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_ctrl(wr_ctrl),
  .ctrl_run(ctrl_run), .ctrl_secure(ctrl_secure), .wr_key(wr_key),
  .key_val(key_val), .rst_req(rst_req), .running(running), .secure(secure),
  .lfsr_q(lfsr_q), .cnt_q(cnt_q), .load_q(load_q)
);

// File: tb/sim_wdt_keyed.sv
module sim_wdt_keyed;
  localparam int CLK_P = 10;
  localparam int CW = 16;

  logic clk = 0, rst_n = 0;
  logic tick = 0, wr_load = 0, wr_ctrl = 0, ctrl_run = 0, ctrl_secure = 0, wr_key = 0;
  logic [CW-1:0] load_val = '0;
  logic [7:0] key_val = '0;
  logic rst_req;

  int checks = 0, fails = 0, fires = 0, cycles = 0;
  string tag = "R1";

  always #(CLK_P/2) clk = ~clk;

  wdt_keyed #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_load(wr_load), .load_val(load_val),
    .wr_ctrl(wr_ctrl), .ctrl_run(ctrl_run), .ctrl_secure(ctrl_secure),
    .wr_key(wr_key), .key_val(key_val), .rst_req(rst_req));

  function automatic int nxt(input int k);
    int v;
    v = (k * 2) % 256;
    if (k >= 128) v = v ^ 99;
    return v;
  endfunction

  // behavioural reference model
  int m_run, m_sec, m_key, m_cnt, m_load;
  bit m_rst;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_sec = 0; m_key = 0; m_cnt = 0; m_load = 0; m_rst = 0;
    end else begin
      bit ok, f;
      ok = (m_sec == 0) || (int'(key_val) == m_key && m_key != 0);
      f = 0;
      if (m_run != 0) begin
        if (wr_key && !ok) f = 1;
        else if (wr_key) begin
          m_cnt = m_load;
          if (m_sec != 0) m_key = nxt(m_key);
        end else if (tick) begin
          if (m_cnt == 0) f = 1; else m_cnt = m_cnt - 1;
        end
      end else begin
        if (wr_ctrl && ctrl_run) begin
          if (ctrl_secure && m_key == 0) f = 1;
          else begin m_run = 1; m_sec = int'(ctrl_secure); m_cnt = m_load; end
        end
        if (!f && wr_key) m_key = int'(key_val);
      end
      if (!f && wr_load) m_load = int'(load_val);
      if (f) begin m_run = 0; m_sec = 0; m_key = 0; m_cnt = 0; m_load = 0; end
      m_rst = f;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (rst_req !== m_rst) begin
        fails++;
        $display("FAIL %s: rst_req actual %0b expected %0b at cycle %0d", tag, rst_req, m_rst, cycles);
      end
      if (rst_req) fires++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic step(input bit t, input bit wl, input int lv, input bit wc,
                      input bit cr, input bit cs, input bit wk, input int kv);
    tick = t; wr_load = wl; load_val = CW'(lv); wr_ctrl = wc; ctrl_run = cr;
    ctrl_secure = cs; wr_key = wk; key_val = 8'(kv);
    @(negedge clk);
    tick = 0; wr_load = 0; wr_ctrl = 0; wr_key = 0;
  endtask
  task automatic idle();          step(0,0,0,0,0,0,0,0); endtask
  task automatic tk(input int n); for (int i = 0; i < n; i++) step(1,0,0,0,0,0,0,0); endtask
  task automatic ld(input int v); step(0,1,v,0,0,0,0,0); endtask
  task automatic key(input int v); step(0,0,0,0,0,0,1,v); endtask
  task automatic ctl(input bit r, input bit s); step(0,0,0,1,r,s,0,0); endtask

  task automatic expect_fires(input int base, input int d, input string r);
    #1;
    checks++;
    if (fires - base != d) begin
      fails++;
      $display("FAIL %s: reset requests actual %0d expected %0d", r, fires - base, d);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    int b, k;
    do_reset();
    tag = "R1"; b = fires;
    #1; checks++;
    if (rst_req !== 1'b0) begin fails++; $display("FAIL R1: rst_req actual %0b expected 0", rst_req); end
    tk(10); idle(); expect_fires(b, 0, "R1");

    tag = "R2"; do_reset(); b = fires;
    ld(0); ctl(0, 0); tk(3); idle(); expect_fires(b, 0, "R2");

    tag = "R3"; do_reset(); b = fires;
    ld(5); ctl(1, 0); tk(5); idle(); expect_fires(b, 0, "R2");
    tk(1); idle(); expect_fires(b, 1, "R3");
    tag = "R10";
    #1; checks++;
    if (rst_req !== 1'b0) begin fails++; $display("FAIL R10: rst_req actual %0b expected 0", rst_req); end
    tk(20); idle(); expect_fires(b, 1, "R10");

    tag = "R4"; do_reset(); b = fires;
    ld(3); ctl(1, 0);
    for (int i = 0; i < 10; i++) begin tk(3); key(i * 37); end
    idle(); expect_fires(b, 0, "R4");

    tag = "R12"; do_reset(); b = fires;
    ld(4); key(8'hAA); ctl(1, 1);
    tk(2); key(8'hAA); tk(2); key(8'h37); tk(2); key(8'h6E); tk(2);
    idle(); expect_fires(b, 0, "R12");
    key(8'h66); idle(); expect_fires(b, 1, "R12");

    tag = "R5"; do_reset(); b = fires;
    ld(3); key(1); ctl(1, 1); k = 1;
    for (int i = 0; i < 20; i++) begin tk(2); key(k); k = nxt(k); end
    idle(); expect_fires(b, 0, "R5");
    tk(4); idle(); expect_fires(b, 1, "R5");

    tag = "R6"; do_reset(); b = fires;
    ld(1000); key(8'h5A); ctl(1, 1); tk(3); key(8'h5B); idle(); expect_fires(b, 1, "R6");

    tag = "R7"; do_reset(); b = fires;
    ld(50); ctl(1, 1); idle(); expect_fires(b, 1, "R7");

    tag = "R8"; do_reset(); b = fires;
    ld(3); key(8'h11); ctl(1, 0); ctl(1, 1); key(8'h99); tk(2); key(8'h42);
    idle(); expect_fires(b, 0, "R8");

    tag = "R9"; do_reset(); b = fires;
    ld(2); ctl(1, 0); tk(2); step(1,0,0,0,0,0,1,8'h3C); tk(2);
    idle(); expect_fires(b, 0, "R9");
    do_reset(); b = fires;
    ld(0); key(8'hAA); ctl(1, 1); step(1,0,0,0,0,0,1,8'hAA); step(1,0,0,0,0,0,1,8'h37);
    idle(); expect_fires(b, 0, "R9");

    tag = "R11"; do_reset(); b = fires;
    ld(2); ctl(1, 0); ld(6); key(0); tk(6); idle(); expect_fires(b, 0, "R11");
    tk(1); idle(); expect_fires(b, 1, "R11");

    idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule